// File: doc/BRIEF.md
# Wormhole Packet Switch

This block is a small crossbar switch for multi-flit packets that move under wormhole flow control. Each input port takes flits over a valid/ready channel into a two-entry queue. The first flit of a packet names an output port. Once that flit wins the output, the output stays bound to that input until the last flit of the packet has gone out. Later flits follow one behind the other through the shallow queue, and the switch never holds a whole packet.

When the downstream side stops taking flits, the bound output holds its flit in place. The input queue fills, and the upstream ready falls, so the whole packet stops where it stands. Head flits from other inputs that want a bound output wait at the front of their own queues and, in time, push back on their own senders. When several head flits ask for the same free output in one cycle, a round-robin pointer for that output picks one of them.

A flit is `{type[1:0], payload[PAYLOAD_W-1:0]}`. The destination output index sits in the low `DEST_W` bits of the payload of a head or single-flit packet.

Top module: `wh_switch`

## Requirements
- R1: While rst_ni is low, every out_valid_o bit is 0 whatever the inputs do, and no flit offered during reset is stored. Right after release, every in_ready_o bit is 1 and every out_valid_o bit is 0.
- R2: The flit type is held in bits [FLIT_W-1:FLIT_W-2] and is coded as body=2'b00, head=2'b01, tail=2'b10 and single=2'b11. A head or single flit goes to the output whose index equals payload[DEST_W-1:0], and every flit leaves the switch unchanged.
- R3: An output that has presented a head flit stays bound to that input until the input's tail flit is accepted (out_valid_o and out_ready_i both high). While bound, it presents only that input's flits.
- R4: A single flit (2'b11) claims and frees its output in the same accepted transfer. If it is accepted in the cycle it is first presented, the output is free in the next cycle.
- R5: A free output grants the first input that has a head or single flit for it, searching upward from its pointer and wrapping at N_PORTS-1. Each grant moves that output's pointer to the winner plus one, modulo N_PORTS. Reset sets every pointer to 0.
- R6: Each input queue holds FIFO_DEPTH (2) flits. in_ready_o is low exactly when the queue for that input is full, even in a cycle where a flit is leaving it.
- R7: While out_valid_o is high and out_ready_i is low, the next cycle still shows out_valid_o high with the same out_flit_o.
- R8: Flits from one input leave in the order they arrived, and none is lost or duplicated. A flit accepted at an input clock edge can be presented at an output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_PORTS | Flit offered, one bit per input |
| in_ready_o | output | N_PORTS | Input queue can take a flit |
| in_flit_i | input | N_PORTS*FLIT_W | Input flits, input p in slice p*FLIT_W |
| out_valid_o | output | N_PORTS | Flit presented, one bit per output |
| out_ready_i | input | N_PORTS | Downstream takes the presented flit |
| out_flit_o | output | N_PORTS*FLIT_W | Output flits, output p in slice p*FLIT_W |

## Verification
Several inputs send head flits to one output at the same time, so the round-robin order is tested under contention. A pointer that fails to move past the winner would starve an input and shift every later grant. Long runs of low out_ready_i fill the queues and hold packets in place. A switch that releases the lock on a body flit, or that lets a waiting head flit in while a packet is still bound, would interleave flits and corrupt the compared stream. A queue that lowers ready one entry too early or too late would show up as an in_ready_o mismatch. Single-flit packets test release in the same cycle as the grant: a design that keeps the lock would stall the next winner by one cycle.

// File: rtl/wh_pkg.sv
package wh_pkg;
  typedef enum logic [1:0] {
    FT_BODY = 2'b00,
    FT_HEAD = 2'b01,
    FT_TAIL = 2'b10,
    FT_SOLO = 2'b11
  } ftype_e;
endpackage

// File: rtl/wh_in_fifo.sv
module wh_in_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_valid_i,
  output logic         push_ready_o,
  input  logic [W-1:0] push_data_i,
  output logic         head_valid_o,
  output logic [W-1:0] head_data_o,
  input  logic         pop_i
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push, pop;

  assign push_ready_o = (cnt_q != CNT_W'(DEPTH));
  assign head_valid_o = (cnt_q != '0);
  assign head_data_o  = mem_q[rd_q];
  assign push = push_valid_i & push_ready_o;
  assign pop  = pop_i & head_valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_q] <= push_data_i;
  end

  // R6: occupancy never exceeds the queue depth
  a_r6_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH)) else $error("queue overflow");
  // R8: a pop request only arrives while a flit is present
  a_r8_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> head_valid_o) else $error("pop of empty queue");
endmodule

// File: rtl/wh_rr_arb.sv
module wh_rr_arb #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr_i) + k;
      if (j >= N) j = j - N;
      if (!any_o && req_i[j]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(j);
      end
    end
  end
endmodule

// File: rtl/wh_out_ctrl.sv
module wh_out_ctrl
  import wh_pkg::*;
#(
  parameter int N       = 4,
  parameter int FLIT_W  = 10,
  parameter int DEST_W  = 2,
  parameter int OUT_IDX = 0
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N-1:0]                head_valid_i,
  input  logic [N-1:0][FLIT_W-1:0]    head_flit_i,
  input  logic                        out_ready_i,
  output logic                        out_valid_o,
  output logic [FLIT_W-1:0]           out_flit_o,
  output logic [N-1:0]                pop_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     req;
  logic [IDX_W-1:0] win_idx, sel, owner_q, ptr_q;
  logic             win_any, locked_q, fire, closes;
  ftype_e           sel_type;

  for (genvar i = 0; i < N; i++) begin : g_req
    ftype_e t;
    assign t      = ftype_e'(head_flit_i[i][FLIT_W-1 -: 2]);
    assign req[i] = head_valid_i[i] && (t == FT_HEAD || t == FT_SOLO) &&
                    (head_flit_i[i][DEST_W-1:0] == DEST_W'(OUT_IDX));
    assign pop_o[i] = fire && (sel == IDX_W'(i));
  end

  wh_rr_arb #(.N(N), .IDX_W(IDX_W)) u_arb (
    .req_i(req), .ptr_i(ptr_q), .idx_o(win_idx), .any_o(win_any)
  );

  assign sel         = locked_q ? owner_q : win_idx;
  assign out_valid_o = locked_q ? head_valid_i[owner_q] : win_any;
  assign out_flit_o  = head_flit_i[sel];
  assign sel_type    = ftype_e'(out_flit_o[FLIT_W-1 -: 2]);
  assign closes      = (sel_type == FT_TAIL) || (sel_type == FT_SOLO);
  assign fire        = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      owner_q  <= '0;
      ptr_q    <= '0;
    end else if (!locked_q) begin
      if (win_any) begin
        ptr_q <= (win_idx == IDX_W'(N - 1)) ? '0 : win_idx + 1'b1;
        // a presented flit is held bound unless it closes the packet now
        if (!(fire && closes)) begin
          locked_q <= 1'b1;
          owner_q  <= win_idx;
        end
      end
    end else if (fire && closes) begin
      locked_q <= 1'b0;
    end
  end

  // R7: a stalled flit stays on the output unchanged
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_flit_o))
    else $error("stalled flit changed");
  // R3: the binding survives until a closing flit leaves
  a_r3_owner_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q && !(fire && closes) |=> locked_q && $stable(owner_q))
    else $error("lock lost early");
  // R4: an accepted single flit on a free output leaves it free
  a_r4_solo_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_q && fire && sel_type == FT_SOLO |=> !locked_q)
    else $error("single flit kept lock");
  // R5: the arbiter only grants an actual requester
  a_r5_grant_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_any |-> req[win_idx]) else $error("grant without request");
endmodule

// File: rtl/wh_switch.sv
module wh_switch
  import wh_pkg::*;
#(
  parameter int N_PORTS    = 4,
  parameter int PAYLOAD_W  = 8,
  parameter int FIFO_DEPTH = 2,
  parameter int DEST_W     = (N_PORTS > 1) ? $clog2(N_PORTS) : 1,
  parameter int FLIT_W     = PAYLOAD_W + 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_PORTS-1:0]          in_valid_i,
  output logic [N_PORTS-1:0]          in_ready_o,
  input  logic [N_PORTS*FLIT_W-1:0]   in_flit_i,
  output logic [N_PORTS-1:0]          out_valid_o,
  input  logic [N_PORTS-1:0]          out_ready_i,
  output logic [N_PORTS*FLIT_W-1:0]   out_flit_o
);
  logic [N_PORTS-1:0][FLIT_W-1:0]  in_arr, head_flit, out_arr;
  logic [N_PORTS-1:0]              head_valid, in_pop;
  logic [N_PORTS-1:0][N_PORTS-1:0] pop_mat;

  assign in_arr     = in_flit_i;
  assign out_flit_o = out_arr;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_in
    wh_in_fifo #(.W(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .push_valid_i (in_valid_i[i]),
      .push_ready_o (in_ready_o[i]),
      .push_data_i  (in_arr[i]),
      .head_valid_o (head_valid[i]),
      .head_data_o  (head_flit[i]),
      .pop_i        (in_pop[i])
    );

    logic [N_PORTS-1:0] col;
    always_comb begin
      for (int o = 0; o < N_PORTS; o++) col[o] = pop_mat[o][i];
    end
    assign in_pop[i] = |col;

    // R8: an input flit is taken by at most one output per cycle
    a_r8_single_taker: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(col)) else $error("flit taken twice");
  end

  for (genvar o = 0; o < N_PORTS; o++) begin : g_out
    wh_out_ctrl #(
      .N(N_PORTS), .FLIT_W(FLIT_W), .DEST_W(DEST_W), .OUT_IDX(o)
    ) u_ctrl (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .head_valid_i (head_valid),
      .head_flit_i  (head_flit),
      .out_ready_i  (out_ready_i[o]),
      .out_valid_o  (out_valid_o[o]),
      .out_flit_o   (out_arr[o]),
      .pop_o        (pop_mat[o])
    );
  end
endmodule

// File: tb/wh_switch_bench.sv
module wh_switch_bench;
  localparam int N  = 4;
  localparam int PW = 8;
  localparam int FW = PW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0]    in_valid, in_ready, out_valid, out_ready;
  logic [N*FW-1:0] in_flit, out_flit;
  logic [FW-1:0]   drv_flit [N];

  always_comb begin
    for (int i = 0; i < N; i++) in_flit[i*FW +: FW] = drv_flit[i];
  end

  wh_switch #(.N_PORTS(N), .PAYLOAD_W(PW), .FIFO_DEPTH(2)) u_wh_switch (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_flit_i(in_flit),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_flit_o(out_flit)
  );

  int checks = 0, errors = 0;
  logic [FW-1:0] sendq [N][$];
  logic [FW-1:0] mq [N][$];
  bit m_lock [N];
  int m_owner [N];
  int m_ptr [N];
  bit acc [N];
  bit prev_stall [N];
  logic [FW-1:0] prev_flit [N];
  int gen_total = 0, del_total = 0;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  initial begin
    bit done;
    int cyc;
    in_valid  = '0;
    out_ready = '0;
    for (int i = 0; i < N; i++) begin
      drv_flit[i] = '0; m_lock[i] = 0; m_owner[i] = 0; m_ptr[i] = 0;
      acc[i] = 0; prev_stall[i] = 0; prev_flit[i] = '0;
    end
    // traffic: early packets all aim at output 0 to force contention
    for (int i = 0; i < N; i++) begin
      for (int p = 0; p < 60; p++) begin
        int len, dest;
        len  = 1 + int'($urandom % 4);
        dest = (p < 15) ? 0 : int'($urandom % N);
        for (int f = 0; f < len; f++) begin
          logic [1:0] t;
          logic [PW-1:0] pl;
          if (len == 1) t = 2'b11;
          else if (f == 0) t = 2'b01;
          else if (f == len - 1) t = 2'b10;
          else t = 2'b00;
          pl = PW'($urandom);
          if (f == 0) pl[1:0] = 2'(dest);
          sendq[i].push_back({t, pl});
          gen_total++;
        end
      end
    end

    // R1: reset with inputs offered
    in_valid = '1;
    for (int i = 0; i < N; i++) drv_flit[i] = {2'b11, 8'h00};
    out_ready = '1;
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R1", "out_valid in reset", int'(out_valid), 0);
    in_valid = '0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == '1, "R1", "in_ready after reset", int'(in_ready), 15);
    chk(out_valid == '0, "R1", "out_valid after reset", int'(out_valid), 0);

    done = 0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      bit idle_src;
      bit m_rdy [N];
      bit ev [N];
      bit fire [N];
      bit grant [N];
      int src [N];
      logic [FW-1:0] ef [N];
      @(negedge clk);
      cyc++;
      idle_src = 1;
      for (int i = 0; i < N; i++) begin
        if (acc[i]) begin in_valid[i] = 1'b0; acc[i] = 0; end
        if (!in_valid[i] && sendq[i].size() > 0 && ($urandom % 4) != 0) begin
          in_valid[i] = 1'b1;
          drv_flit[i] = sendq[i][0];
        end
        if (sendq[i].size() > 0) idle_src = 0;
      end
      for (int o = 0; o < N; o++) begin
        if (idle_src) out_ready[o] = 1'b1;
        else if ((cyc % 300) < 60) out_ready[o] = (($urandom % 4) == 0);
        else out_ready[o] = (($urandom % 4) != 0);
      end
      #1;
      // R7: stalled flit held, checked against the previous sample
      for (int o = 0; o < N; o++) begin
        if (prev_stall[o]) begin
          chk(out_valid[o] == 1'b1, "R7", "valid held", int'(out_valid[o]), 1);
          chk(out_flit[o*FW +: FW] == prev_flit[o], "R7", "flit held",
              int'(out_flit[o*FW +: FW]), int'(prev_flit[o]));
        end
      end
      for (int i = 0; i < N; i++) begin
        m_rdy[i] = (mq[i].size() < 2);
        chk(in_ready[i] == m_rdy[i], "R6", "in_ready", int'(in_ready[i]), int'(m_rdy[i]));
      end
      for (int o = 0; o < N; o++) begin
        string tag;
        ev[o] = 0; grant[o] = 0; src[o] = 0; ef[o] = '0;
        if (m_lock[o]) begin
          src[o] = m_owner[o];
          if (mq[src[o]].size() > 0) begin ev[o] = 1; ef[o] = mq[src[o]][0]; end
        end else begin
          for (int k = 0; k < N; k++) begin
            int j;
            j = (m_ptr[o] + k) % N;
            if (!grant[o] && mq[j].size() > 0 && mq[j][0][FW-2] == 1'b1 &&
                int'(mq[j][0][1:0]) == o) begin
              grant[o] = 1; src[o] = j; ev[o] = 1; ef[o] = mq[j][0];
            end
          end
        end
        if (m_lock[o]) tag = "R3";
        else if (ev[o] && ef[o][FW-1 -: 2] == 2'b11) tag = "R4";
        else tag = "R5";
        chk(out_valid[o] == ev[o], tag, "out_valid", int'(out_valid[o]), int'(ev[o]));
        if (ev[o])
          chk(out_flit[o*FW +: FW] == ef[o], "R2", "out_flit",
              int'(out_flit[o*FW +: FW]), int'(ef[o]));
        fire[o] = ev[o] && out_ready[o];
        prev_stall[o] = out_valid[o] && !out_ready[o];
        prev_flit[o]  = out_flit[o*FW +: FW];
      end
      // advance the reference to the next edge
      for (int o = 0; o < N; o++) begin
        bit closing;
        closing = ef[o][FW-1];
        if (grant[o]) begin
          m_ptr[o] = (src[o] + 1) % N;
          if (!(fire[o] && closing)) begin m_lock[o] = 1; m_owner[o] = src[o]; end
        end else if (m_lock[o] && fire[o] && closing) begin
          m_lock[o] = 0;
        end
        if (fire[o]) begin
          void'(mq[src[o]].pop_front());
          del_total++;
        end
      end
      for (int i = 0; i < N; i++) begin
        if (in_valid[i] && m_rdy[i]) begin
          mq[i].push_back(drv_flit[i]);
          void'(sendq[i].pop_front());
          acc[i] = 1;
        end
      end
      done = 1;
      for (int i = 0; i < N; i++)
        if (sendq[i].size() > 0 || mq[i].size() > 0 || (in_valid[i] && !acc[i])) done = 0;
    end

    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", del_total, gen_total);
    end
    chk(del_total == gen_total, "R8", "flits delivered", del_total, gen_total);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule